// File: doc/BRIEF.md
# Selector-Indexed Configuration Blob Read Port

This block lets a host read a set of fixed configuration items, each a byte array held in on-chip constant logic, through two registers. The host writes a 16-bit key to the selector register to choose an item. It then reads the data register repeatedly. Each data read returns the next bytes of the chosen item in string order and moves a byte offset forward by the access width. Writing the selector again clears that offset.

The key carries two flags in its top bits. Bit 15 chooses between the generic item class and the architecture-specific class. Bit 14 is a write-enable flag that has no effect, because every data write is dropped. Two items are always present: a four-character signature and a feature bitmap. A parameter sets how many further generic and architecture-specific items exist and how long they are. Their contents are computed. Reading past the end of an item returns zero bytes. Keys with no item behave as empty items.

Responses leave a two-state machine. In `ST_IDLE` no response is shown. Any accepted read moves the machine to `ST_RESP`, where `rsp_valid` is high for one cycle with the registered read data. From `ST_RESP`, another read keeps the machine in `ST_RESP`; anything else returns it to `ST_IDLE`. Selector writes and data writes never leave `ST_IDLE` on their own.

Top module: `cfgblob_port`

## Requirements
- R1: After reset the selected key is 0x0000, the offset is 0, and `rsp_valid` is low.
- R2: A write with `req_sel`=1 loads the key from `req_wdata[15:0]` and clears the offset to 0.
- R3: Every read (`req_valid`=1, `req_write`=0) gives exactly one response. `rsp_valid` is high in the single cycle after the request edge, and only then. Responses come back in request order.
- R4: `req_size` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. Item byte offset+k appears in `rsp_rdata[8k+7:8k]`. Lanes at or above the width read zero. A data read advances the offset by the width.
- R5: Bytes at item positions at or beyond the item length read 0x00. A read that straddles the end returns the real bytes up to the length and zeros in the rest of its lanes.
- R6: A write with `req_sel`=0 (data register) changes nothing. The offset and the key are kept, whatever key bit 14 holds.
- R7: Key bit 15 selects the architecture-specific class, bits 13:0 give the index within the class, and bit 14 does not take part in item decode.
- R8: Generic index 0 is a 4-byte signature whose byte k is character k of `SIG_TEXT` (default "HWCF").
- R9: Generic index 1 is a 4-byte little-endian feature word. Byte 0 = {6'b0, `DMA_PRESENT`, 1'b1}, and bytes 1 to 3 are zero.
- R10: Generic indices 2..`NUM_GEN`-1 have length `GEN_LEN_BASE`+index and byte k = (16*index + k) mod 256. Architecture indices 0..`NUM_ARCH`-1 have length `ARCH_LEN`+index and byte k = (0xC0 + 32*index + k) mod 256.
- R11: A key with no item (any other index in either class) is a zero-length item, so every data read returns all zeros.
- R12: The offset saturates at 2^`OFS_W`-1 instead of wrapping.
- R13: A read of the selector register (`req_sel`=1) responds with zero and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 1 = selector register, 0 = data register |
| req_size | input | 2 | Access width code (1/2/4/8 bytes) |
| req_wdata | input | 64 | Write data; only bits 15:0 are used, and only for selector writes |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 64 | Read response data, lowest item byte in the lowest lane |

## Verification
The assertions assume the host issues at most one request per cycle. They also assume `req_size` is meaningful only on data reads, and that reset is applied before the first request. The bench keeps to this by driving every request from one task on the falling edge, with a single-cycle valid. It holds `req_valid` low throughout reset. The saturation check relies on an architecture item longer than the offset range, so the bench elaborates the port with a narrow `OFS_W` and a long `ARCH_LEN`.

// File: rtl/cfgblob_pkg.sv
package cfgblob_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rsp_state_e;

    function automatic logic [3:0] access_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/cfgblob_offset.sv
module cfgblob_offset #(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [3:0]       step,
    output logic [OFS_W-1:0] ofs
);
    localparam logic [OFS_W:0] OFS_MAX = {1'b0, {OFS_W{1'b1}}};

    logic [OFS_W:0]   sum;
    logic [OFS_W-1:0] ofs_d;

    always_comb begin
        sum = {1'b0, ofs} + (OFS_W+1)'(step);
        if (clr) begin
            ofs_d = '0;
        end else if (adv) begin
            ofs_d = (sum > OFS_MAX) ? OFS_MAX[OFS_W-1:0] : sum[OFS_W-1:0];
        end else begin
            ofs_d = ofs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ofs <= '0;
        else        ofs <= ofs_d;
    end

    // R2
    ofs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ofs == '0));

    // R6
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(ofs));

    // R12
    ofs_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && ofs == OFS_MAX[OFS_W-1:0]) |=> (ofs == OFS_MAX[OFS_W-1:0]));

endmodule

// File: rtl/cfgblob_byte_rom.sv
module cfgblob_byte_rom #(
    parameter logic [31:0] SIG_TEXT     = "HWCF",
    parameter bit          DMA_PRESENT  = 1'b0,
    parameter int          NUM_GEN      = 4,
    parameter int          GEN_LEN_BASE = 3,
    parameter int          NUM_ARCH     = 1,
    parameter int          ARCH_LEN     = 10,
    parameter int          AW           = 20
) (
    input  logic          is_arch,
    input  logic [13:0]   idx,
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    logic [AW-1:0] len;
    logic [7:0]    val;

    always_comb begin
        len = '0;
        val = 8'h00;
        if (!is_arch) begin
            if (idx == 14'd0) begin
                len = AW'(4);
                val = SIG_TEXT[(5'd24 - {addr[1:0], 3'b000}) +: 8];
            end else if (idx == 14'd1) begin
                len = AW'(4);
                val = (addr[1:0] == 2'd0) ? {6'b0, DMA_PRESENT, 1'b1} : 8'h00;
            end else if (32'(idx) < 32'(NUM_GEN)) begin
                len = AW'(32'(GEN_LEN_BASE) + 32'(idx));
                val = 8'(32'(idx) * 32'd16 + 32'(addr));
            end
        end else if (32'(idx) < 32'(NUM_ARCH)) begin
            len = AW'(32'(ARCH_LEN) + 32'(idx));
            val = 8'(32'hC0 + 32'(idx) * 32'd32 + 32'(addr));
        end
        data = (addr < len) ? val : 8'h00;
    end

endmodule

// File: rtl/cfgblob_port.sv
module cfgblob_port
    import cfgblob_pkg::*;
#(
    parameter logic [31:0] SIG_TEXT     = "HWCF",
    parameter bit          DMA_PRESENT  = 1'b0,
    parameter int          OFS_W        = 16,
    parameter int          NUM_GEN      = 4,
    parameter int          GEN_LEN_BASE = 3,
    parameter int          NUM_ARCH     = 1,
    parameter int          ARCH_LEN     = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_sel,
    input  logic [1:0]  req_size,
    input  logic [63:0] req_wdata,
    output logic        rsp_valid,
    output logic [63:0] rsp_rdata
);
    localparam int LANES = 8;
    localparam int AW    = OFS_W + 4;

    rsp_state_e       state_q, state_d;
    logic             key_arch_q;
    logic [13:0]      key_idx_q;
    logic [OFS_W-1:0] ofs;
    logic [63:0]      rdata_q, gather;
    logic [3:0]       nbytes;
    logic             sel_wr, data_rd, any_rd;
    logic             wdata_unused;
    logic [7:0]       lane_byte [LANES];

    assign sel_wr       = req_valid && req_write && req_sel;
    assign data_rd      = req_valid && !req_write && !req_sel;
    assign any_rd       = req_valid && !req_write;
    assign nbytes       = access_bytes(req_size);
    assign wdata_unused = ^{req_wdata[63:16], req_wdata[14]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_arch_q <= 1'b0;
            key_idx_q  <= '0;
        end else if (sel_wr) begin
            key_arch_q <= req_wdata[15];
            key_idx_q  <= req_wdata[13:0];
        end
    end

    cfgblob_offset #(.OFS_W(OFS_W)) u_ofs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sel_wr),
        .adv   (data_rd),
        .step  (nbytes),
        .ofs   (ofs)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [AW-1:0] lane_addr;
        assign lane_addr = AW'(ofs) + AW'(j);

        cfgblob_byte_rom #(
            .SIG_TEXT     (SIG_TEXT),
            .DMA_PRESENT  (DMA_PRESENT),
            .NUM_GEN      (NUM_GEN),
            .GEN_LEN_BASE (GEN_LEN_BASE),
            .NUM_ARCH     (NUM_ARCH),
            .ARCH_LEN     (ARCH_LEN),
            .AW           (AW)
        ) u_rom (
            .is_arch (key_arch_q),
            .idx     (key_idx_q),
            .addr    (lane_addr),
            .data    (lane_byte[j])
        );

        assign gather[8*j +: 8] = (data_rd && (4'(j) < nbytes)) ? lane_byte[j] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (any_rd) rdata_q <= gather;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_rd)  state_d = ST_RESP;
            ST_RESP: if (!any_rd) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rsp_valid ? rdata_q : 64'd0;
    end

    // R3
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd |=> rsp_valid);

    // R3
    rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> !rsp_valid);

    // R6
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> ($stable(key_idx_q) && $stable(key_arch_q)));

    // R13
    sel_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_sel) |=> (rsp_rdata == 64'd0));

    // R4
    narrow_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && req_size == 2'd0) |=> (rsp_rdata[63:8] == 56'd0));

endmodule

// File: tb/cfgblob_port_tb.sv
module cfgblob_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T_OFS_W    = 6;
    localparam int T_NUM_GEN  = 4;
    localparam int T_GEN_BASE = 3;
    localparam int T_NUM_ARCH = 1;
    localparam int T_ARCH_LEN = 70;
    localparam int T_OFS_MAX  = (1 << T_OFS_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_sel = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [63:0] req_wdata = 64'd0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    int m_ofs  = 0;
    logic [15:0] m_key = 16'h0000;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgblob_port #(
        .SIG_TEXT     ("HWCF"),
        .DMA_PRESENT  (1'b1),
        .OFS_W        (T_OFS_W),
        .NUM_GEN      (T_NUM_GEN),
        .GEN_LEN_BASE (T_GEN_BASE),
        .NUM_ARCH     (T_NUM_ARCH),
        .ARCH_LEN     (T_ARCH_LEN)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (req_sel),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    function automatic logic [7:0] model_byte(input logic [15:0] key, input int pos);
        int idx = int'(key[13:0]);
        int len = 0;
        logic [7:0] v = 8'h00;
        logic [31:0] sig = "HWCF";
        if (!key[15]) begin
            if (idx == 0) begin
                len = 4;
                if (pos < 4) v = sig[8*(3-pos) +: 8];
            end else if (idx == 1) begin
                len = 4;
                v = (pos == 0) ? 8'h03 : 8'h00;
            end else if (idx < T_NUM_GEN) begin
                len = T_GEN_BASE + idx;
                v = 8'(idx*16 + pos);
            end
        end else if (idx < T_NUM_ARCH) begin
            len = T_ARCH_LEN + idx;
            v = 8'(32'hC0 + idx*32 + pos);
        end
        return (pos < len) ? v : 8'h00;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic sel, input logic [1:0] sz, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_sel   = sel;
        req_size  = sz;
        req_wdata = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        req_sel   = 1'b0;
    endtask

    task automatic select(input logic [15:0] key);
        issue(1'b1, 1'b1, 2'd0, {48'hDEAD_BEEF_0000, key});
        m_key = key;
        m_ofs = 0;
    endtask

    task automatic data_write(input logic [63:0] wd);
        issue(1'b1, 1'b0, 2'd3, wd);
    endtask

    task automatic read_data(input logic [1:0] sz, input string req);
        int n = 1 << sz;
        logic [63:0] e = 64'd0;
        for (int k = 0; k < n; k++) e[8*k +: 8] = model_byte(m_key, m_ofs + k);
        exp_q.push_back(e);
        tag_q.push_back(req);
        issue(1'b0, 1'b0, sz, 64'd0);
        m_ofs = (m_ofs + n > T_OFS_MAX) ? T_OFS_MAX : m_ofs + n;
    endtask

    task automatic read_selector(input string req);
        exp_q.push_back(64'd0);
        tag_q.push_back(req);
        issue(1'b0, 1'b1, 2'd3, 64'd0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected response", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);

        // R1 R8: default key 0, signature
        read_data(2'd2, "R1 R8 signature after reset");
        idle();
        @(negedge clk);
        check("R3 single pulse", {63'd0, rsp_valid}, 64'd0);

        // R9 R5: feature word then zeros
        select(16'h0001);
        read_data(2'd3, "R9 R5 feature word straddle");

        // R10 R4 R5: generic item 2 (length 5)
        select(16'h0002);
        read_data(2'd0, "R4 R10 1-byte");
        read_data(2'd1, "R4 R10 2-byte");
        read_data(2'd2, "R5 R4 straddle 4-byte");
        read_data(2'd3, "R5 past end");

        // R6: data write ignored
        select(16'h0003);
        data_write(64'hFFFF_FFFF_FFFF_FFFF);
        read_data(2'd1, "R6 write ignored");
        select(16'h4003);
        data_write(64'h1234_5678_9ABC_DEF0);
        read_data(2'd2, "R7 R6 bit14 alias");

        // R11 unknown keys
        select(16'h0009);
        read_data(2'd3, "R11 unknown generic");
        select(16'h8005);
        read_data(2'd3, "R11 unknown arch");

        // R7 arch class with bit14 set
        select(16'hC000);
        read_data(2'd3, "R7 arch item");

        // R13 selector read
        read_selector("R13 selector read zero");
        read_data(2'd0, "R13 offset kept");

        // R2: reselect restarts at 0
        select(16'h8000);
        read_data(2'd1, "R2 offset cleared");

        // R12 saturation
        select(16'h8000);
        for (int i = 0; i < 8; i++) read_data(2'd3, "R12 walk");
        read_data(2'd0, "R12 saturated byte");
        read_data(2'd0, "R12 still saturated");
        idle();

        repeat (4) @(negedge clk);
        check("R3 all responses seen", 64'(exp_q.size()), 64'd0);
        check("R3 idle after traffic", {63'd0, rsp_valid}, 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule